// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a memory controller and four battery-backed SRAM banks. It takes one active-low chip enable plus a two-bit bank select and drives four active-low bank enables, so that only the selected bank sees the access. It also watches a power-good indication from an external supply comparator. While the supply is out of tolerance, every bank enable is held inactive, which write-protects the stored data. The block also drives an active-low system reset to the processor.

An access that is already running when the failure is detected may finish. It is cut off after a bounded number of cycles. Once power returns, the bank enables stay blocked for a recovery interval. The system reset is held low for a separate recovery interval before it is released. Every interval is a parameter counted in clock cycles. The power-good input is synchronised inside the block. The asynchronous reset puts the block into the power-fail state.

Top module: `pf_ce_gate`

## Requirements
- R1: With `ce_n` high, all four `bank_ce_n` bits are 1. With `ce_n` low in normal operation, exactly one bit is 0, and its index is {sel_b, sel_a}: 0 selects bit 0, 1 selects bit 1, 2 selects bit 2 and 3 selects bit 3. `bank_ce_n` follows `ce_n` and the selects combinationally.
- R2: If `ce_n` is high when the failure is detected, every `bank_ce_n` bit is 1 from the 3rd rising edge after `pwr_good_raw` is first sampled low, and `ce_n` has no effect. The 1st edge is the one that samples the low level.
- R3: If `ce_n` is low when the failure is detected, the selected bank stays enabled while `ce_n` stays low, for at most WPT_CYC cycles. All bits are 1 from the (WPT_CYC+3)th edge after `pwr_good_raw` is first sampled low.
- R4: During the grace period of R3, a rise of `ce_n` ends the grace period. A later fall of `ce_n` enables no bank.
- R5: `sys_rst_n` is 0 from the 3rd rising edge after `pwr_good_raw` is first sampled low.
- R6: After `pwr_good_raw` goes high, `ce_n` is ignored and all bits stay 1 up to and including the (CER_CYC+2)th edge that samples it high. From the (CER_CYC+3)th edge, R1 applies again.
- R7: After `pwr_good_raw` goes high, `sys_rst_n` stays 0 up to and including the (REC_CYC+1)th edge that samples it high. It becomes 1 on the (REC_CYC+2)th edge.
- R8: While `rst_n` is low, every `bank_ce_n` bit is 1 and `sys_rst_n` is 0. After `rst_n` is released, the recovery of R6 and R7 runs as if power had just returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable from the controller, active low |
| sel_a | input | 1 | Bank select, low bit |
| sel_b | input | 1 | Bank select, high bit |
| pwr_good_raw | input | 1 | Asynchronous supply-good flag from the comparator |
| bank_ce_n | output | 4 | Conditioned bank enables, active low |
| sys_rst_n | output | 1 | System reset to the processor, active low |

## Verification
The assertions assume that `pwr_good_raw` only changes at a safe distance from the sampling edge. They also assume that `ce_n` and the selects do not bounce between edges, so the cycle counts seen at the synchroniser input match those seen inside the block. The bench drives every input at the falling clock edge. It holds the selects steady before it lowers `ce_n`, which meets the zero setup time the decode relies on. It never returns power while a grace period is still open.

// File: rtl/pf_ce_gate.sv
module pf_ce_gate #(
  parameter int WPT_CYC = 20000,
  parameter int CER_CYC = 8000000,
  parameter int REC_CYC = 8000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       pwr_good_raw,
  output logic [3:0] bank_ce_n,
  output logic       sys_rst_n
);
  localparam int MAXA = (WPT_CYC > CER_CYC) ? WPT_CYC : CER_CYC;
  localparam int MAXC = (MAXA > REC_CYC) ? MAXA : REC_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WPT_LAST = CW'(WPT_CYC - 1);
  localparam logic [CW-1:0] CER_LAST = CW'(CER_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  typedef enum logic [1:0] {S_FAIL, S_GRACE, S_RECOV, S_RUN} st_t;

  logic          pg_s1, pg_s2;
  st_t           st;
  logic [CW-1:0] cnt, rcnt;
  logic [1:0]    held;
  logic          rst_q;
  logic [3:0]    dec_n, grace_n;

  wire [1:0] sel = {sel_b, sel_a};

  for (genvar i = 0; i < 4; i++) begin : g_bank
    assign dec_n[i]   = ce_n | (sel  != 2'(i));
    assign grace_n[i] = ce_n | (held != 2'(i));
  end

  assign bank_ce_n = (st == S_RUN)   ? dec_n   :
                     (st == S_GRACE) ? grace_n : 4'hF;
  assign sys_rst_n = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
    end else begin
      pg_s1 <= pwr_good_raw;
      pg_s2 <= pg_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_FAIL;
      cnt  <= '0;
      held <= 2'd0;
    end else begin
      case (st)
        S_RUN: if (!pg_s2) begin
          cnt  <= '0;
          held <= sel;
          st   <= ce_n ? S_FAIL : S_GRACE;
        end
        S_GRACE: begin
          if (ce_n || cnt == WPT_LAST) st <= S_FAIL;
          else                         cnt <= cnt + 1'b1;
        end
        S_FAIL: if (pg_s2) begin
          cnt <= '0;
          st  <= S_RECOV;
        end
        default: begin
          if (!pg_s2)               st <= S_FAIL;
          else if (cnt == CER_LAST) st <= S_RUN;
          else                      cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt  <= '0;
      rst_q <= 1'b0;
    end else if (!pg_s2) begin
      rcnt  <= '0;
      rst_q <= 1'b0;
    end else if (!rst_q) begin
      if (rcnt == REC_LAST) rst_q <= 1'b1;
      else                  rcnt  <= rcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pf_ce_gate_chk.sv
module pf_ce_gate_chk #(
  parameter int WPT_CYC = 20000,
  parameter int CER_CYC = 8000000,
  parameter int REC_CYC = 8000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       pwr_good_raw,
  input logic [3:0] bank_ce_n,
  input logic       sys_rst_n
);
  localparam int MAXA = (WPT_CYC > CER_CYC) ? WPT_CYC : CER_CYC;
  localparam int MAXC = (MAXA > REC_CYC) ? MAXA : REC_CYC;
  localparam int CW   = $clog2(MAXC + 8);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] fail_cnt, good_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_cnt <= '0;
      good_cnt <= '0;
    end else if (pwr_good_raw) begin
      fail_cnt <= '0;
      if (good_cnt != TOP) good_cnt <= good_cnt + 1'b1;
    end else begin
      good_cnt <= '0;
      if (fail_cnt != TOP) fail_cnt <= fail_cnt + 1'b1;
    end
  end

  AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (bank_ce_n == 4'hF)); // R1
  AST_AT_MOST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_ce_n)); // R1
  AST_PROTECT_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt >= CW'(WPT_CYC + 3)) |-> (bank_ce_n == 4'hF)); // R3
  AST_RESET_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt >= CW'(3)) |-> !sys_rst_n); // R5
  AST_RESET_RELEASE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (good_cnt >= CW'(REC_CYC + 2))); // R7
  AST_BANKS_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good_raw && good_cnt < CW'(CER_CYC + 3) && fail_cnt == '0 &&
     $past(bank_ce_n) == 4'hF) |-> (bank_ce_n == 4'hF)); // R6
endmodule

bind pf_ce_gate pf_ce_gate_chk #(
  .WPT_CYC(WPT_CYC), .CER_CYC(CER_CYC), .REC_CYC(REC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .pwr_good_raw(pwr_good_raw),
  .bank_ce_n(bank_ce_n), .sys_rst_n(sys_rst_n)
);

// File: tb/pf_ce_gate_tb.sv
module pf_ce_gate_tb;
  localparam int WPT = 6;
  localparam int CER = 10;
  localparam int REC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, sel_a = 1'b0, sel_b = 1'b0, pwr_good_raw = 1'b0;
  logic [3:0] bank_ce_n;
  logic sys_rst_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pf_ce_gate #(.WPT_CYC(WPT), .CER_CYC(CER), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_a(sel_a), .sel_b(sel_b),
    .pwr_good_raw(pwr_good_raw), .bank_ce_n(bank_ce_n), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic c, input logic [1:0] s);
    @(negedge clk);
    ce_n = c; {sel_b, sel_a} = s;
  endtask

  // R6 R7: power returns; count edges from the first one that samples it high
  task automatic t_recover();
    drive(1'b1, 2'd0);
    #1 ce_n = 1'b0;
    pwr_good_raw = 1'b1;
    for (int i = 1; i <= REC + 2; i++) begin
      edge_after();
      if (i == CER + 2) chk("R6 blocked", bank_ce_n, 4'b1111);
      if (i == CER + 3) chk("R6 reopened", bank_ce_n, 4'b1110);
      if (i == REC + 1) chk("R7 held", {3'b0, sys_rst_n}, 4'b0000);
      if (i == REC + 2) chk("R7 released", {3'b0, sys_rst_n}, 4'b0001);
    end
    drive(1'b1, 2'd0);
  endtask

  task automatic t_reset();
    #2 chk("R8 banks in reset", bank_ce_n, 4'b1111);
    chk("R8 rst in reset", {3'b0, sys_rst_n}, 4'b0000);
    pwr_good_raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edge_after();
    chk("R8 after release", {3'b0, sys_rst_n}, 4'b0000);
  endtask

  task automatic t_decode();
    drive(1'b1, 2'd3);
    #1 chk("R1 idle", bank_ce_n, 4'b1111);
    for (int s = 0; s < 4; s++) begin
      drive(1'b1, 2'(s));
      #1 ce_n = 1'b0;
      #1 chk("R1 decode", bank_ce_n, ~(4'b0001 << s));
    end
    drive(1'b1, 2'd0);
    #1 chk("R1 release", bank_ce_n, 4'b1111);
  endtask

  task automatic t_fail_idle();
    drive(1'b1, 2'd3);
    pwr_good_raw = 1'b0;
    repeat (3) edge_after();
    chk("R5 rst low", {3'b0, sys_rst_n}, 4'b0000);
    drive(1'b0, 2'd3);
    edge_after();
    chk("R2 protected", bank_ce_n, 4'b1111);
  endtask

  task automatic t_grace_timeout();
    drive(1'b0, 2'd2);
    pwr_good_raw = 1'b0;
    for (int i = 1; i <= WPT + 3; i++) begin
      edge_after();
      if (i == WPT + 2) chk("R3 access kept", bank_ce_n, 4'b1011);
      if (i == WPT + 3) chk("R3 cut off", bank_ce_n, 4'b1111);
    end
  endtask

  task automatic t_grace_end();
    drive(1'b0, 2'd1);
    pwr_good_raw = 1'b0;
    repeat (4) edge_after();
    chk("R4 in grace", bank_ce_n, 4'b1101);
    drive(1'b1, 2'd1);
    edge_after();
    drive(1'b0, 2'd1);
    edge_after();
    chk("R4 new access blocked", bank_ce_n, 4'b1111);
    drive(1'b1, 2'd1);
  endtask

  initial begin
    t_reset();
    t_recover();
    t_decode();
    t_fail_idle();
    t_recover();
    t_grace_timeout();
    t_recover();
    t_grace_end();
    t_recover();
    t_decode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule